// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes received frames as a byte stream and places them in memory through a ring of 8-byte buffer descriptors. The last four bytes of each frame are the frame check sequence. The engine stores them like any other data and never checks them. Before it stores any byte, it walks the ring from its current position. It accepts the frame only if enough empty buffers lie ahead to hold all of it. It then spreads the bytes over consecutive buffers. Each buffer holds at most a programmable number of bytes. After filling a buffer, the engine writes that buffer's byte count and updated status back to its descriptor. It raises a one-cycle event for every buffer it completes.

A descriptor occupies two big-endian 32-bit words in memory. The word at the descriptor address holds the status flags in bits 31:16 and the byte count in bits 15:0. The next word holds the buffer address. All memory traffic goes through a single request/acknowledge port. Descriptor accesses are word accesses, and frame data is written one byte per request. The stream carries the total frame length, counting the check sequence, on `s_len`. That value must stay stable for the whole frame and must be at least 1.

Five registers are reached through a simple write strobe and a registered read. Index 0 is the control register, whose bit 0 is the enable. Index 1 is the kick register. Index 2 is the ring base. Index 3 is the maximum buffer size. Index 4 is the receive control register, which holds the maximum frame length in bits 31:16. Reads return the addressed register one cycle after `reg_addr` is presented.

Top module: `rx_scatter_engine`

## Requirements
- R1: After reset the buffer-size register (index 3) reads 0x7F0, the receive control register (index 4) reads 0x05EE0001, and the kick register (index 1) reads 0, meaning reception is disabled.
- R2: A write to the kick register (index 1) turns reception on only if three conditions hold: control bit 0 is set, reception is currently off, and the descriptor at the current ring position has its empty flag (bit 15) set. The kick register reads back the receive-enabled state in bit 24.
- R3: Before any data is written, the ring is walked from the current position, and each empty descriptor adds one buffer size to the available capacity. If a descriptor without the empty flag is reached before the capacity is at least the frame length, the frame is dropped. A dropped frame causes no memory write and no event, and the ring position does not move.
- R4: Each accepted buffer receives min(remaining bytes, buffer size) consecutive frame bytes, starting at its buffer address and kept in stream order. Its descriptor's first word is rewritten with that count in bits 15:0 and the flags with bit 15 cleared and all other flags kept.
- R5: A write to the buffer-size register keeps value bits 10:4 and clears the rest. If bits 10:4 of the written value are all zero, the register becomes 0x7F0.
- R6: A frame longer than 2032 bytes has only its first 2032 bytes stored, and the rest of its input is discarded. Its last descriptor gets the truncated flag (bit 0) and the length-violation flag (bit 5).
- R7: A stored frame longer than the limit in bits 31:16 of the receive control register sets the length-violation flag (bit 5) on its last descriptor, and sets bit 0 only when R6 applies. Writes to that register keep bits 26:16 and 5:0.
- R8: Every buffer that is not the last of its frame raises `evt_rxb` for one cycle. The last buffer gets the last flag (bit 11) and raises `evt_rxf` for one cycle instead.
- R9: After a stored frame, reception stays on only if control bit 0 is set and the descriptor at the new ring position has the empty flag set.
- R10: After a descriptor is used, the ring position moves to the ring base if that descriptor's wrap flag (bit 13) is set, and otherwise 8 bytes further. A write to the ring base register (index 2, bits 1:0 forced to zero) also moves the current position to the base.
- R11: Clearing control bit 0 turns reception off on the next cycle.
- R12: A frame that arrives while reception is off, or that is dropped under R3, is consumed from the stream up to its last byte without any memory write. The following frame is then stored from its own first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_len | input | LW | Frame length in bytes, check sequence included |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Write of one byte (`mem_wdata[7:0]`) instead of a word |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| evt_rxb | output | 1 | Intermediate buffer completed |
| evt_rxf | output | 1 | Frame completed |

## Verification
The bench goes after four corner cases. The first is a frame whose length is an exact multiple of the buffer size; a capacity comparison that is off by one would refuse it or ask for an extra buffer. The second is a walk that meets a full descriptor partway through; a design that checks space lazily would leave earlier buffers half-written instead of leaving memory untouched. The third is a frame that crosses the wrap descriptor and so ends on a descriptor that has already been used; a wrong wrap would write past the ring, and a wrong re-arm would leave reception on. The fourth is a set of oversize frames over, at and under the two length limits; a design that mixes up the limits would set the wrong flag, and one that fails to drain would leave the stream misaligned.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WALK, ST_RD0, ST_RD1, ST_DATA, ST_WB, ST_TDRAIN, ST_ARM, ST_DRAIN
  } rxs_state_e;

  // descriptor flag bit positions (software decodes these)
  localparam int F_EMPTY  = 15;
  localparam int F_WRAP   = 13;
  localparam int F_LAST   = 11;
  localparam int F_LENERR = 5;
  localparam int F_TRUNC  = 0;

  // register indices
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_KICK = 3'd1;
  localparam logic [2:0] REG_RING = 3'd2;
  localparam logic [2:0] REG_BSZ  = 3'd3;
  localparam logic [2:0] REG_RCTL = 3'd4;

  localparam int          BSW       = 11;
  localparam logic [10:0] BSZ_MAX   = 11'h7F0;
  localparam logic [31:0] RCTL_RST  = 32'h05EE0001;
  localparam logic [31:0] RCTL_MASK = 32'h07FF003F;
  localparam int          EN_BIT    = 24;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs import rxs_pkg::*; #(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           rx_en,
  output logic           ctrl_en,
  output logic [AW-1:0]  ring_base,
  output logic [BSW-1:0] buf_size,
  output logic [15:0]    max_frm,
  output logic           kick,
  output logic           ring_wr
);
  logic [31:0] rctl_q;
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ring_base <= '0;
      buf_size  <= BSZ_MAX;
      rctl_q    <= RCTL_RST;
      kick      <= 1'b0;
      ring_wr   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      kick      <= reg_wr && (reg_addr == REG_KICK);
      ring_wr   <= reg_wr && (reg_addr == REG_RING);
      reg_rdata <= rd_mux;
      if (reg_wr) begin
        case (reg_addr)
          REG_CTRL: ctrl_en   <= reg_wdata[0];
          REG_RING: ring_base <= {reg_wdata[AW-1:2], 2'b00};
          REG_BSZ:  buf_size  <= (reg_wdata[10:4] == 7'd0) ? BSZ_MAX : {reg_wdata[10:4], 4'h0};
          REG_RCTL: rctl_q    <= reg_wdata & RCTL_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_CTRL: rd_mux[0] = ctrl_en;
      REG_KICK: rd_mux[EN_BIT] = rx_en;
      REG_RING: rd_mux[AW-1:0] = ring_base;
      REG_BSZ:  rd_mux[BSW-1:0] = buf_size;
      REG_RCTL: rd_mux = rctl_q;
      default:  rd_mux = '0;
    endcase
  end

  assign max_frm = rctl_q[31:16];
endmodule

// File: rtl/rxs_len_calc.sv
module rxs_len_calc #(
  parameter int LW   = 16,
  parameter int MAXF = 2032
) (
  input  logic [LW-1:0] frm_len,
  input  logic [15:0]   max_frm,
  output logic [LW-1:0] eff_len,
  output logic          trunc,
  output logic          lenerr
);
  localparam logic [LW-1:0] CAP = LW'(MAXF);

  always_comb begin
    trunc   = frm_len > CAP;
    eff_len = trunc ? CAP : frm_len;
    lenerr  = trunc || (32'(eff_len) > 32'(max_frm));
  end
endmodule

// File: rtl/rxs_fsm.sv
module rxs_fsm import rxs_pkg::*; #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_en,
  input  logic [AW-1:0]  ring_base,
  input  logic [BSW-1:0] buf_size,
  input  logic           kick,
  input  logic           ring_wr,
  input  logic [LW-1:0]  eff_len,
  input  logic           trunc,
  input  logic           lenerr,
  input  logic           s_valid,
  input  logic           s_last,
  input  logic [7:0]     s_data,
  output logic           s_ready,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_byte,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           evt_rxb,
  output logic           evt_rxf,
  output logic           rx_en
);
  rxs_state_e    state;
  logic [AW-1:0] cur, wp, baddr;
  logic [LW-1:0] want, rem, nbuf, boff;
  logic [15:0]   dflags, wb_flags;
  logic          f_tr, f_lg, kick_pend;

  wire [LW-1:0]  bsz      = LW'(buf_size);
  wire [15:0]    rd_flags = mem_rdata[31:16];
  wire           done     = mem_req && mem_ack;
  wire           last_buf = (rem == nbuf);
  wire [AW-1:0]  walk_nx  = rd_flags[F_WRAP] ? ring_base : wp + AW'(8);
  wire [AW-1:0]  wb_nx    = dflags[F_WRAP] ? ring_base : wp + AW'(8);

  always_comb begin
    wb_flags = dflags;
    wb_flags[F_EMPTY] = 1'b0;
    if (last_buf) begin
      wb_flags[F_LAST]   = 1'b1;
      wb_flags[F_LENERR] = dflags[F_LENERR] | f_lg;
      wb_flags[F_TRUNC]  = dflags[F_TRUNC] | f_tr;
    end
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_byte = 1'b0;
    mem_addr = wp; mem_wdata = '0;
    case (state)
      ST_WALK, ST_RD0: mem_req = 1'b1;
      ST_RD1: begin mem_req = 1'b1; mem_addr = wp + AW'(4); end
      ST_ARM: begin mem_req = 1'b1; mem_addr = cur; end
      ST_DATA: begin
        mem_req = s_valid; mem_we = 1'b1; mem_byte = 1'b1;
        mem_addr = baddr + AW'(boff); mem_wdata = {24'd0, s_data};
      end
      ST_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = {wb_flags, 16'(nbuf)}; end
      default: ;
    endcase
  end

  assign s_ready = ((state == ST_DATA) && done) || (state == ST_TDRAIN) || (state == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cur <= '0; wp <= '0; baddr <= '0;
      want <= '0; rem <= '0; nbuf <= '0; boff <= '0; dflags <= '0;
      f_tr <= 1'b0; f_lg <= 1'b0; kick_pend <= 1'b0; rx_en <= 1'b0;
      evt_rxb <= 1'b0; evt_rxf <= 1'b0;
    end else begin
      evt_rxb <= 1'b0;
      evt_rxf <= 1'b0;
      if (kick && ctrl_en && !rx_en) kick_pend <= 1'b1;
      case (state)
        ST_IDLE:
          if (kick_pend) state <= ST_ARM;
          else if (s_valid) begin
            f_tr <= trunc; f_lg <= lenerr;
            rem <= eff_len; want <= eff_len; wp <= cur;
            state <= rx_en ? ST_WALK : ST_DRAIN;
          end
        ST_WALK:
          if (done) begin
            if (!rd_flags[F_EMPTY]) state <= ST_DRAIN;
            else if (want <= bsz) begin wp <= cur; state <= ST_RD0; end
            else begin want <= want - bsz; wp <= walk_nx; end
          end
        ST_RD0:
          if (done) begin
            dflags <= rd_flags;
            nbuf   <= (rem < bsz) ? rem : bsz;
            state  <= ST_RD1;
          end
        ST_RD1:
          if (done) begin baddr <= mem_rdata[AW-1:0]; boff <= '0; state <= ST_DATA; end
        ST_DATA:
          if (done) begin
            boff <= boff + LW'(1);
            if (boff + LW'(1) == nbuf) state <= ST_WB;
          end
        ST_WB:
          if (done) begin
            rem <= rem - nbuf;
            wp  <= wb_nx;
            if (last_buf) begin
              evt_rxf <= 1'b1;
              cur     <= wb_nx;
              state   <= f_tr ? ST_TDRAIN : ST_ARM;
            end else begin
              evt_rxb <= 1'b1;
              state   <= ST_RD0;
            end
          end
        ST_TDRAIN: if (s_valid && s_last) state <= ST_ARM;
        ST_ARM:
          if (done) begin
            rx_en     <= rd_flags[F_EMPTY] && ctrl_en;
            kick_pend <= 1'b0;
            state     <= ST_IDLE;
          end
        ST_DRAIN: if (s_valid && s_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (ring_wr) cur <= ring_base;
      if (!ctrl_en) rx_en <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine import rxs_pkg::*; #(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int MAXF = 2032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic [LW-1:0] s_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          evt_rxb,
  output logic          evt_rxf
);
  logic           ctrl_en, rx_en, kick, ring_wr, trunc, lenerr;
  logic [AW-1:0]  ring_base;
  logic [BSW-1:0] buf_size;
  logic [15:0]    max_frm;
  logic [LW-1:0]  eff_len;

  rxs_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_en(rx_en),
    .ctrl_en(ctrl_en), .ring_base(ring_base), .buf_size(buf_size),
    .max_frm(max_frm), .kick(kick), .ring_wr(ring_wr)
  );

  rxs_len_calc #(.LW(LW), .MAXF(MAXF)) u_len (
    .frm_len(s_len), .max_frm(max_frm), .eff_len(eff_len),
    .trunc(trunc), .lenerr(lenerr)
  );

  rxs_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ring_base(ring_base),
    .buf_size(buf_size), .kick(kick), .ring_wr(ring_wr), .eff_len(eff_len),
    .trunc(trunc), .lenerr(lenerr), .s_valid(s_valid), .s_last(s_last),
    .s_data(s_data), .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .evt_rxb(evt_rxb),
    .evt_rxf(evt_rxf), .rx_en(rx_en)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int AW  = 32,
  parameter int BSW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           ctrl_en,
  input logic           rx_en,
  input logic [BSW-1:0] buf_size,
  input logic           mem_req,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic           evt_rxb,
  input logic           evt_rxf
);
  // R11
  ctrl_off_chk: assert property (@(posedge clk) disable iff (rst) !ctrl_en |=> !rx_en);
  // R2
  arm_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(rx_en) |-> $past(ctrl_en));
  // R5
  bsz_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_size[3:0] == 4'h0) && (buf_size != '0));
  // R8
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst) !(evt_rxb && evt_rxf));
  // R8
  frm_gap_chk: assert property (@(posedge clk) disable iff (rst) evt_rxf |=> !evt_rxf);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind rx_scatter_engine rxs_checker #(.AW(AW), .BSW(rxs_pkg::BSW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .rx_en(rx_en), .buf_size(buf_size),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .evt_rxb(evt_rxb), .evt_rxf(evt_rxf)
);

// File: tb/sim_rx_scatter_engine.sv
`timescale 1ns/100ps
module sim_rx_scatter_engine;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [15:0] s_len = '0;
  logic mem_req, mem_we, mem_byte, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic evt_rxb, evt_rxf;

  always #2 clk = ~clk;

  rx_scatter_engine u0 (.*);

  logic [7:0] mem [0:16383];
  int n_checks = 0, n_err = 0;
  int qa[$], qd[$];
  bit qb[$];
  int cnt_rxb = 0, cnt_rxf = 0;
  int m_cur = 0, m_bsz = 'h7F0, m_maxfl = 1518;
  bit m_en = 0, m_ctrl = 0;
  localparam int RB = 'h100;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int rd16(input int a);
    return {mem[a & 16383], mem[(a + 1) & 16383]};
  endfunction
  function automatic int rd32(input int a);
    return {mem[a & 16383], mem[(a+1) & 16383], mem[(a+2) & 16383], mem[(a+3) & 16383]};
  endfunction
  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + i / 256) & 255);
  endfunction
  task automatic wr32(input int a, input int d);
    for (int k = 0; k < 4; k++) mem[(a + k) & 16383] = 8'(d >> (24 - 8 * k));
  endtask

  // memory responder and running write comparison
  always @(negedge clk) begin
    if (evt_rxb) cnt_rxb++;
    if (evt_rxf) cnt_rxf++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && !rst) begin
      if (mem_we) begin
        if (qa.size() == 0) check(0, "R4/R12 unexpected write", int'(mem_addr), -1);
        else begin
          automatic int ea = qa.pop_front();
          automatic int ed = qd.pop_front();
          automatic bit eb = qb.pop_front();
          if (eb) check(mem_byte && int'(mem_addr) == ea && int'(mem_wdata[7:0]) == ed,
                        "R4 data byte", int'(mem_addr), ea);
          else check(!mem_byte && int'(mem_addr) == ea && int'(mem_wdata) == ed,
                     "R4 descriptor write", int'(mem_wdata), ed);
        end
        if (mem_byte) mem[mem_addr[13:0]] = mem_wdata[7:0];
        else wr32(int'(mem_addr), int'(mem_wdata));
      end else mem_rdata = rd32(int'(mem_addr));
      mem_ack = 1'b1;
    end
  end

  task automatic reg_w(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_r(input int a, output int d);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); d = int'(reg_rdata);
  endtask

  task automatic init_ring(input int full_mask);
    for (int i = 0; i < 4; i++) begin
      automatic int fl = ((full_mask >> i) & 1) ? 0 : 'h8000;
      if (i == 3) fl |= 'h2000;
      wr32(RB + 8 * i, fl << 16);
      wr32(RB + 8 * i + 4, 'h1000 + i * 'h800);
    end
  endtask

  // behavioural model: builds the expected write list of one frame
  task automatic model(input int len, input int seed, output int erb, output int erf);
    automatic int size, want, a, fl, ba, n, rem, idx = 0;
    automatic bit tr, lg, ok = 0;
    erb = 0; erf = 0;
    if (!m_en) return;
    tr = len > 2032; size = tr ? 2032 : len; lg = tr || size > m_maxfl;
    want = size; a = m_cur;
    forever begin
      fl = rd16(a);
      if (!(fl & 'h8000)) break;
      if (want <= m_bsz) begin ok = 1; break; end
      want -= m_bsz;
      a = (fl & 'h2000) ? RB : a + 8;
    end
    if (!ok) return;
    a = m_cur; rem = size;
    while (rem > 0) begin
      fl = rd16(a); ba = rd32(a + 4);
      n = rem < m_bsz ? rem : m_bsz;
      for (int k = 0; k < n; k++) begin
        qa.push_back(ba + k); qd.push_back(int'(pat(seed, idx))); qb.push_back(1); idx++;
      end
      rem -= n;
      fl &= ~'h8000;
      if (rem == 0) fl |= 'h0800 | (lg ? 'h20 : 0) | (tr ? 1 : 0);
      qa.push_back(a); qd.push_back((fl << 16) | n); qb.push_back(0);
      if (rem == 0) erf++; else erb++;
      a = (fl & 'h2000) ? RB : a + 8;
    end
    m_cur = a;
    m_en = 0;
    m_en = 1;
  endtask

  task automatic run_frame(input int len, input int seed, input string tag);
    automatic int erb, erf, d;
    automatic bit was_en = m_en, stored;
    automatic int qn;
    model(len, seed, erb, erf);
    stored = (erf != 0);
    qn = qa.size();
    cnt_rxb = 0; cnt_rxf = 0;
    for (int i = 0; i < len; i++) begin
      automatic bit got = 0;
      @(negedge clk);
      s_valid = 1'b1; s_data = pat(seed, i); s_last = (i == len - 1); s_len = 16'(len);
      while (!got) begin
        #1 got = s_ready;
        @(posedge clk);
        if (!got) @(negedge clk);
      end
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    repeat (30) @(negedge clk);
    check(qa.size() == 0, {tag, " R4 all writes done"}, qa.size(), 0);
    check(cnt_rxb == erb, {tag, " R8 rxb count"}, cnt_rxb, erb);
    check(cnt_rxf == erf, {tag, " R8 rxf count"}, cnt_rxf, erf);
    if (stored) m_en = m_ctrl && ((rd16(m_cur) & 'h8000) != 0);
    else m_en = was_en;
    reg_r(1, d);
    check(d == (m_en ? 32'h0100_0000 : 0), {tag, " R9 enable after frame"}, d, m_en ? 32'h0100_0000 : 0);
    if (qn == 0) qn = 0;
  endtask

  task automatic kick_and_model;
    reg_w(1, 0);
    repeat (12) @(negedge clk);
    if (m_ctrl && !m_en) m_en = (rd16(m_cur) & 'h8000) != 0;
  endtask

  initial begin
    automatic int d;
    for (int i = 0; i < 16384; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    reg_r(3, d); check(d == 'h7F0, "R1 bufsz reset", d, 'h7F0);
    reg_r(4, d); check(d == 'h05EE0001, "R1 rx control reset", d, 'h05EE0001);
    reg_r(1, d); check(d == 0, "R1 disabled at reset", d, 0);
    // R5 buffer size shaping
    reg_w(3, 0);     reg_r(3, d); check(d == 'h7F0, "R5 zero selects max", d, 'h7F0);
    reg_w(3, 'h123); reg_r(3, d); check(d == 'h120, "R5 low bits dropped", d, 'h120);
    reg_w(3, 'h0F);  reg_r(3, d); check(d == 'h7F0, "R5 masked zero selects max", d, 'h7F0);
    reg_w(3, 'h40);  m_bsz = 'h40;
    // R7 control register mask
    reg_w(4, 32'hFFFF_FFFF); reg_r(4, d); check(d == 'h07FF003F, "R7 write mask", d, 'h07FF003F);
    reg_w(4, 'h05EE0001);
    // R2 / R10 ring set-up and kick rules
    init_ring(0);
    reg_w(2, RB | 3); m_cur = RB;
    reg_r(2, d); check(d == RB, "R10 ring base low bits", d, RB);
    kick_and_model;
    reg_r(1, d); check(d == 0, "R2 kick ignored while control off", d, 0);
    reg_w(0, 1); m_ctrl = 1;
    init_ring(1);
    kick_and_model;
    reg_r(1, d); check(d == 0, "R2 kick ignored on full descriptor", d, 0);
    init_ring(0);
    kick_and_model;
    reg_r(1, d); check(d == 'h0100_0000, "R2 kick enables", d, 'h0100_0000);
    // R4 R8 single buffer, then multi-buffer across the wrap (R10, R9)
    run_frame(60, 1, "single buffer");
    run_frame(150, 2, "three buffers wrap");
    // R12 frame while disabled is drained
    run_frame(40, 3, "disabled drain");
    init_ring(0);
    kick_and_model;
    // R4 exact multiple of buffer size; also checks alignment after the drain
    run_frame(128, 4, "exact multiple");
    // R3 not enough empty buffers: dropped untouched, pointer kept
    wr32(RB + 24, 32'h2000_0000);
    run_frame(150, 5, "R3 refused");
    run_frame(30, 6, "R3 after refusal");
    // R6 R7 length limits
    init_ring(0);
    reg_w(2, RB); m_cur = RB;
    reg_w(3, 0); m_bsz = 'h7F0;
    kick_and_model;
    run_frame(2100, 7, "R6 truncated");
    run_frame(1600, 8, "R7 over max frame");
    reg_w(4, 'h07F80000); m_maxfl = 'h7F8;
    run_frame(2032, 9, "R7 at cap no flags");
    // R11 control off disables at once, R12 drain afterwards
    reg_w(0, 0); m_ctrl = 0; m_en = 0;
    reg_r(1, d); check(d == 0, "R11 disabled by control", d, 0);
    run_frame(20, 10, "R12 drained when off");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule